// File: doc/BRIEF.md
# Cartridge Character-Memory Bank Switcher

This block sits on a game cartridge between the console CPU, the picture processor (PPU) and the character (tile pattern) ROM. It watches CPU stores into the upper ROM window and keeps a small set of bank registers. A store to the even port records which register the following stores should target. A store to the odd port then loads that register with a bank number.

The PPU address lines A12..A10 are decoded continuously to form the upper character ROM address. The lower 4 KB of pattern space uses two 2 KB banks, and the upper 4 KB uses four 1 KB banks. PPU A10 is passed straight through to the ROM inside the 2 KB banks. Indices 6 and 7 belong to program-memory banking, which this block does not implement. Stores to those indices are accepted but leave the character mapping untouched.

The registers are clocked by the falling edge of PHI2. The ROM address path is purely combinational, so the PPU sees the mapping with no added latency.

Top module: `chr_bank_switch`

## Requirements
- R1: A register store is decoded only when cpuRw=0, romSelN=0, cpuA14=0 and cpuA13=0 at the falling edge of phi2. Any other combination leaves the stored index and every bank unchanged.
- R2: A decoded store with cpuA0=0 targets the index port. A decoded store with cpuA0=1 targets the bank data port.
- R3: An index-port store keeps cpuData[2:0] as the target index. The index persists across any number of following data-port stores.
- R4: A data-port store loads the full cpuData byte into the bank whose number equals the stored index (0..5). The new value drives chrA from that same falling edge onward.
- R5: When ppuA[2]=0 (PPU A12 low), ppuA[1] picks bank 0 (value 0) or bank 1 (value 1). chrA[7:1] equals bits 7:1 of that bank, and chrA[0] equals ppuA[0]. Bit 0 of the bank has no effect.
- R6: When ppuA[2]=1, chrA equals the full byte of bank 2 + ppuA[1:0].
- R7: A data-port store while the index is 6 or 7 changes no chrA value for any ppuA.
- R8: With rstN low, the index and all banks are 0. After reset, chrA equals {7'b0, ppuA[0]} for ppuA[2]=0, and 0 otherwise.
- R9: chrA follows a change on ppuA combinationally, within the same phi2 phase and with no clock edge needed. chrA carries CHR A17..A10, and ppuA carries PPU A12..A10.
- R10: Storing index 0 and then value 8'h78 yields chrA=8'h78 for ppuA=0 and chrA=8'h79 for ppuA=1. PPU $0000-$07FF therefore maps to ROM $1E000-$1E7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | CPU bus phase clock; registers load on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuRw | input | 1 | CPU read (1) / write (0) |
| romSelN | input | 1 | Active-low ROM window select (A15 high while phi2 high) |
| cpuA14 | input | 1 | CPU address bit 14 |
| cpuA13 | input | 1 | CPU address bit 13 |
| cpuA0 | input | 1 | CPU address bit 0; index port (0) or data port (1) |
| cpuData | input | 8 | CPU data bus |
| ppuA | input | 3 | PPU address bits 12..10 |
| chrA | output | 8 | Character ROM address bits 17..10 |

## Verification
The hardest state to reach from the ports is a data store aimed at index 6 or 7, which must be shown to disturb nothing. This requires every one of the six character banks to hold a distinct, non-zero value beforehand, and all eight PPU windows to be read back after the store. The stimulus first fills every bank with random bytes through directed index/data pairs. Random stores then follow, with decode bits biased so that most of them land and about a quarter of the indices fall on 6 or 7. After every store, the bench sweeps all eight ppuA values against its own bank model.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  localparam int BANK_W   = 8;  // CHR A17..A10
  localparam int IDX_W    = 3;  // stored register index
  localparam int NUM_WIDE = 2;  // 2 KB banks in the lower pattern half
  localparam int NUM_FINE = 4;  // 1 KB banks in the upper pattern half
  localparam int NUM_CHR  = NUM_WIDE + NUM_FINE;
  localparam int PPU_W    = 3;  // PPU A12..A10

  typedef struct packed {
    logic [NUM_CHR-1:0] load;   // one load enable per character bank
    logic [BANK_W-1:0]  value;  // byte to load
  } bankStrobe_t;
endpackage

// File: rtl/chr_bank_ctrl.sv
module chr_bank_ctrl
  import chr_bank_pkg::*;
(
  input  logic              phi2,
  input  logic              rstN,
  input  logic              cpuRw,
  input  logic              romSelN,
  input  logic              cpuA14,
  input  logic              cpuA13,
  input  logic              cpuA0,
  input  logic [BANK_W-1:0] cpuData,
  output bankStrobe_t       strobe,
  output logic [IDX_W-1:0]  selIdx
);
  logic regHit;
  logic dataHit;

  // Mapper window: write, ROM selected, A14 and A13 both low.
  assign regHit  = !cpuRw && !romSelN && !cpuA14 && !cpuA13;
  assign dataHit = regHit && cpuA0;

  always_ff @(negedge phi2 or negedge rstN) begin
    if (!rstN)
      selIdx <= '0;
    else if (regHit && !cpuA0)
      selIdx <= cpuData[IDX_W-1:0];
  end

  assign strobe.value = cpuData;

  // Index decoder; indices beyond the character banks produce no enable.
  for (genvar i = 0; i < NUM_CHR; i++) begin : g_dec
    assign strobe.load[i] = dataHit && (selIdx == IDX_W'(i));
  end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
(
  input  logic                            phi2,
  input  logic                            rstN,
  input  bankStrobe_t                     strobe,
  input  logic [PPU_W-1:0]                ppuA,
  output logic [BANK_W-1:0]               chrA,
  output logic [NUM_CHR-1:0][BANK_W-1:0]  bankView
);
  localparam int SRC_N = 1 << PPU_W;           // mux inputs per output bit
  localparam int WIDE_SLOTS = SRC_N / 2;       // windows in the lower half

  logic [NUM_WIDE-1:0][BANK_W-2:0] wideBank;   // bit 0 never stored
  logic [NUM_FINE-1:0][BANK_W-1:0] fineBank;

  for (genvar w = 0; w < NUM_WIDE; w++) begin : g_wide
    always_ff @(negedge phi2 or negedge rstN) begin
      if (!rstN)
        wideBank[w] <= '0;
      else if (strobe.load[w])
        wideBank[w] <= strobe.value[BANK_W-1:1];
    end
    assign bankView[w] = {wideBank[w], 1'b0};
  end

  for (genvar f = 0; f < NUM_FINE; f++) begin : g_fine
    always_ff @(negedge phi2 or negedge rstN) begin
      if (!rstN)
        fineBank[f] <= '0;
      else if (strobe.load[NUM_WIDE+f])
        fineBank[f] <= strobe.value;
    end
    assign bankView[NUM_WIDE+f] = fineBank[f];
  end

  // One 8:1 mux per output bit, selected by PPU A12..A10.
  for (genvar k = 0; k < BANK_W; k++) begin : g_bit
    logic [SRC_N-1:0] src;
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
      if (s < WIDE_SLOTS) begin : g_low
        if (k == 0) begin : g_pass
          assign src[s] = ppuA[0];
        end else begin : g_reg
          assign src[s] = wideBank[s/2][k-1];
        end
      end else begin : g_high
        assign src[s] = fineBank[s-WIDE_SLOTS][k];
      end
    end
    assign chrA[k] = src[ppuA];
  end
endmodule

// File: rtl/chr_bank_switch.sv
module chr_bank_switch
  import chr_bank_pkg::*;
(
  input  logic              phi2,
  input  logic              rstN,
  input  logic              cpuRw,
  input  logic              romSelN,
  input  logic              cpuA14,
  input  logic              cpuA13,
  input  logic              cpuA0,
  input  logic [7:0]        cpuData,
  input  logic [2:0]        ppuA,
  output logic [7:0]        chrA
);
  bankStrobe_t                     strobe;
  logic [IDX_W-1:0]                selIdx;
  logic [NUM_CHR-1:0][BANK_W-1:0]  bankView;

  chr_bank_ctrl ctrl_i (
    .phi2(phi2), .rstN(rstN), .cpuRw(cpuRw), .romSelN(romSelN),
    .cpuA14(cpuA14), .cpuA13(cpuA13), .cpuA0(cpuA0), .cpuData(cpuData),
    .strobe(strobe), .selIdx(selIdx)
  );

  chr_bank_regs regs_i (
    .phi2(phi2), .rstN(rstN), .strobe(strobe), .ppuA(ppuA),
    .chrA(chrA), .bankView(bankView)
  );
endmodule

// File: rtl/chr_bank_checker.sv
module chr_bank_checker
  import chr_bank_pkg::*;
(
  input logic                            phi2,
  input logic                            rstN,
  input logic                            cpuRw,
  input logic                            romSelN,
  input logic                            cpuA14,
  input logic                            cpuA13,
  input logic                            cpuA0,
  input logic [7:0]                      cpuData,
  input logic [2:0]                      ppuA,
  input logic [7:0]                      chrA,
  input bankStrobe_t                     strobe,
  input logic [IDX_W-1:0]                selIdx,
  input logic [NUM_CHR-1:0][BANK_W-1:0]  bankView
);
  logic busHit;
  assign busHit = !cpuRw && !romSelN && !cpuA14 && !cpuA13;

  // R1: nothing moves without a decoded store
  p_idle_hold_r1: assert property (@(negedge phi2) disable iff (!rstN)
    !busHit |=> ($stable(bankView) && $stable(selIdx)));

  // R2: at most one bank is enabled, never on an index-port store
  p_load_onehot_r2: assert property (@(negedge phi2) disable iff (!rstN)
    $onehot0(strobe.load) && (!cpuA0 -> (strobe.load == '0)));

  // R3: index-port store captures the low data bits
  p_select_capture_r3: assert property (@(negedge phi2) disable iff (!rstN)
    (busHit && !cpuA0) |=> (selIdx == $past(cpuData[IDX_W-1:0])));

  // R4: a 1 KB bank takes the byte written while its index is selected
  p_data_load_r4: assert property (@(negedge phi2) disable iff (!rstN)
    (busHit && cpuA0 && selIdx == 3'd4) |=> (bankView[4] == $past(cpuData)));

  // R5: PPU A10 passes through in the lower pattern half
  p_pass_a10_r5: assert property (@(negedge phi2) disable iff (!rstN)
    !ppuA[2] |-> (chrA[0] == ppuA[0]));

  // R7: program-bank indices leave all character banks alone
  p_prg_index_r7: assert property (@(negedge phi2) disable iff (!rstN)
    (busHit && cpuA0 && selIdx[2:1] == 2'b11) |=> $stable(bankView));
endmodule

bind chr_bank_switch chr_bank_checker chk_i (.*);

// File: tb/chr_bank_switch_tb_top.sv
`timescale 1ns/1ps
module chr_bank_switch_tb_top;
  logic       phi2 = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuRw = 1'b1;
  logic       romSelN = 1'b1;
  logic       cpuA14 = 1'b0;
  logic       cpuA13 = 1'b0;
  logic       cpuA0 = 1'b0;
  logic [7:0] cpuData = 8'h00;
  logic [2:0] ppuA = 3'd0;
  logic [7:0] chrA;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [6];
  logic [2:0] modelIdx = 3'd0;

  always #2 phi2 = ~phi2;   // 250 MHz

  chr_bank_switch dut_i (
    .phi2(phi2), .rstN(rstN), .cpuRw(cpuRw), .romSelN(romSelN),
    .cpuA14(cpuA14), .cpuA13(cpuA13), .cpuA0(cpuA0), .cpuData(cpuData),
    .ppuA(ppuA), .chrA(chrA)
  );

  function automatic logic [7:0] expChr(input logic [2:0] p);
    logic [7:0] v;
    if (!p[2]) begin
      v = model[p[1]];
      return {v[7:1], p[0]};
    end
    return model[2 + p[1:0]];
  endfunction

  task automatic busWrite(input logic rw, input logic rs, input logic a14,
                          input logic a13, input logic a0, input logic [7:0] d);
    @(posedge phi2);
    #1;
    cpuRw = rw; romSelN = rs; cpuA14 = a14; cpuA13 = a13; cpuA0 = a0; cpuData = d;
    @(negedge phi2);
    #1;
    cpuRw = 1'b1; romSelN = 1'b1; cpuA14 = 1'b0; cpuA13 = 1'b0;
    if (!rw && !rs && !a14 && !a13) begin
      if (!a0) modelIdx = d[2:0];
      else if (modelIdx < 3'd6) model[modelIdx] = d;
    end
  endtask

  task automatic regWrite(input logic a0, input logic [7:0] d);
    busWrite(1'b0, 1'b0, 1'b0, 1'b0, a0, d);
  endtask

  task automatic checkMap(input string tag);
    for (int p = 0; p < 8; p++) begin
      ppuA = p[2:0];
      #0.25;
      checks++;
      if (chrA !== expChr(p[2:0])) begin
        fails++;
        $display("FAIL %s ppuA=%0d actual=%h expected=%h", tag, p, chrA, expChr(p[2:0]));
      end
    end
  endtask

  task automatic checkOne(input string tag, input logic [2:0] p, input logic [7:0] e);
    ppuA = p;
    #0.25;
    checks++;
    if (chrA !== e) begin
      fails++;
      $display("FAIL %s ppuA=%0d actual=%h expected=%h", tag, p, chrA, e);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 6; i++) model[i] = 8'h00;
    #9;
    checkMap("R8 reset");
    rstN = 1'b1;
    #4;
    checkMap("R8 after release");

    // R10 worked example, also R4/R5 bit 0 of wide bank ignored
    regWrite(1'b0, 8'h00);
    regWrite(1'b1, 8'h78);
    checkOne("R10 low window", 3'd0, 8'h78);
    checkOne("R10 high window", 3'd1, 8'h79);
    regWrite(1'b1, 8'h79);
    checkOne("R5 bit0 ignored", 3'd0, 8'h78);

    // R3 index persists over several data stores; R6 1 KB banks
    regWrite(1'b0, 8'hF9);   // upper data bits ignored, index 1
    regWrite(1'b1, 8'h11);
    regWrite(1'b1, 8'h22);
    checkMap("R3 persist");
    for (int b = 2; b < 6; b++) begin
      regWrite(1'b0, 8'(b));
      regWrite(1'b1, 8'(8'hA0 + b * 8'h13));
    end
    checkMap("R6 fine banks");

    // R1 non-decoded stores
    regWrite(1'b0, 8'h02);
    busWrite(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A);
    busWrite(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5B);
    busWrite(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5C);
    busWrite(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5D);
    busWrite(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h05);
    checkMap("R1 undecoded ignored");
    regWrite(1'b1, 8'hC3);
    checkMap("R2 data port after index");

    // R7 program indices
    regWrite(1'b0, 8'h06);
    regWrite(1'b1, 8'hFF);
    checkMap("R7 index6");
    regWrite(1'b0, 8'h07);
    regWrite(1'b1, 8'h00);
    checkMap("R7 index7");

    // Random mix; R1/R2/R3/R4/R5/R6/R7/R9
    for (int n = 0; n < 400; n++) begin
      logic rw, rs, a14, a13;
      rw  = ($urandom % 8) == 0;
      rs  = ($urandom % 8) == 0;
      a14 = ($urandom % 8) == 0;
      a13 = ($urandom % 8) == 0;
      busWrite(rw, rs, a14, a13, 1'($urandom), 8'($urandom));
      checkMap("R4 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule